// File: doc/BRIEF.md
# Six-Bank Fast-Page DRAM Controller

This block sits between an internal requester (processor or DMA engine) and a set of up to six fast-page-mode DRAM banks that share one multiplexed address bus, one column strobe, one write strobe and a 16-bit data path. Each bank has its own row strobe and its own configuration word. That word holds a base block, a size in blocks, an access-speed code and an enable bit. One block is 64 KiB. Banks can be packed end to end or left with holes between them. Every bank is off after reset.

A request is matched against the enabled banks. A hit on more than one bank goes to the lowest-numbered bank. The byte offset inside the bank is halved to a word offset. That word offset is then driven as a row half followed by a column half. A request that hits no enabled bank is answered at once with an error flag and touches no row strobe. The requester holds its request until it sees the one-cycle ready pulse.

Column-before-row refresh runs from the moment reset is released, at a default interval, and the interval can be changed later. A due refresh is started only between accesses. An access that is waiting is delayed until the refresh is finished.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, every row strobe, the column strobe and the write strobe are high (inactive), and ready is low. Every bank is disabled, so a first access reports an error.
- R2: A request at byte address A hits bank i when i is enabled and base_i <= A[23:16] < base_i + size_i. Only that bank's row strobe is driven low for the access.
- R3: When several enabled banks hit, only the lowest-numbered one is used.
- R4: A request that hits no enabled bank gives req_ready and req_err high together for one cycle, one cycle after acceptance, and no row strobe falls.
- R5: The word offset W = (A - base_i*65536) >> 1 is split as row = W[21:11] and column = W[10:0]. The row is on dram_addr while the row strobe is low and the column strobe is high, and the column is on dram_addr while the column strobe is low.
- R6: Speed code 0, 1, 2 or 3 (config bits [17:16]) makes ready appear 3, 4, 5 or 5 clocks after the edge that accepts the request. Code 1 adds one row-to-column cycle. Code 2 also adds one extra column-strobe cycle. Code 3 behaves as code 2. Ready is a single-cycle pulse.
- R7: A write drives dram_we_n low and dram_dq_oe high, with dram_dq_out equal to the write data, only while the column strobe is low. A read keeps dram_we_n high and returns on req_rdata the dram_dq_in value present in the last column-strobe cycle.
- R8: A refresh drops the column strobe one cycle before all row strobes fall together. Both strobes are then held low for one more cycle, and both are then released.
- R9: Without any configuration, the first refresh column strobe appears REF_DEF+2 clocks after reset is released.
- R10: Writing interval N to config slot 6 (bits [11:0]) gives, on an idle bus, refresh starts exactly N clocks apart. N must be at least 8.
- R11: A due refresh never starts during an access. It takes priority over a waiting request, so an access delayed this way finishes within 8 clocks.
- R12: A bank with its enable bit (config bit 18) clear is never selected, even when its base and size cover the address. Bank words are written at config slots 0 to 5, with base in bits [7:0] and size in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Slot: 0-5 bank words, 6 refresh interval |
| cfg_wdata | input | 19 | Configuration word |
| req_valid | input | 1 | Request present, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | With ready: no enabled bank hit |
| req_rdata | output | 16 | Read data |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 6 | Per-bank row strobes, active low |
| dram_cas_n | output | 1 | Shared column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | 16 | Write data to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | 16 | Read data from the DRAM |

## Verification
The bench targets several bank-boundary cases:
- the last word of a bank, and the first word after a gap, where a decoder with an off-by-one limit would hit the wrong bank or miss an error;
- a disabled bank that still covers the address, which a decoder ignoring the enable bit would select;
- an overlap, which a highest-index priority would send to the wrong strobe.

It also measures:
- the exact completion latency for each speed code, which a sequencer skipping or doubling a wait cycle would fail;
- the time of the first refresh after reset and the spacing of refreshes after reprogramming, which catch a timer that is off by one or not reloaded on write;
- a burst of reads under a fast refresh, which exposes a refresh cutting into an access or corrupting the returned data.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERR,
    ST_RAS,
    ST_RCD,
    ST_CAS,
    ST_CASW,
    ST_DATA,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_RF_HOLD,
    ST_RF_PRE
  } seq_state_e;

  // speed codes held per bank
  typedef enum logic [1:0] {
    TM_3CLK = 2'd0,
    TM_4CLK = 2'd1,
    TM_5CLK = 2'd2,
    TM_5ALT = 2'd3
  } tm_e;

endpackage

// File: rtl/fpm_bank_regs.sv
module fpm_bank_regs #(
  parameter int NBANK   = 6,
  parameter int BLK_W   = 8,
  parameter int CFG_A_W = 3,
  parameter int CFG_W   = 19
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_A_W-1:0]            cfg_addr,
  input  logic [CFG_W-1:0]              cfg_wdata,
  output logic [NBANK-1:0][BLK_W-1:0]   bank_base,
  output logic [NBANK-1:0][BLK_W-1:0]   bank_size,
  output logic [NBANK-1:0][1:0]         bank_tim,
  output logic [NBANK-1:0]              bank_en
);

  localparam int SZ_LSB = BLK_W;
  localparam int TM_LSB = 2 * BLK_W;
  localparam int EN_BIT = 2 * BLK_W + 2;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_base[g] <= '0;
        bank_size[g] <= '0;
        bank_tim[g]  <= '0;
        bank_en[g]   <= 1'b0;
      end else if (cfg_we && cfg_addr == CFG_A_W'(g)) begin
        bank_base[g] <= cfg_wdata[BLK_W-1:0];
        bank_size[g] <= cfg_wdata[SZ_LSB+BLK_W-1:SZ_LSB];
        bank_tim[g]  <= cfg_wdata[TM_LSB+1:TM_LSB];
        bank_en[g]   <= cfg_wdata[EN_BIT];
      end
    end
  end

endmodule

// File: rtl/fpm_bank_match.sv
module fpm_bank_match #(
  parameter int NBANK  = 6,
  parameter int ADDR_W = 24,
  parameter int BLK_SH = 16,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int BIDX_W = 3,
  localparam int BLK_W = ADDR_W - BLK_SH,
  localparam int OFF_W = ROW_W + COL_W + 1
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NBANK-1:0][BLK_W-1:0]   bank_base,
  input  logic [NBANK-1:0][BLK_W-1:0]   bank_size,
  input  logic [NBANK-1:0][1:0]         bank_tim,
  input  logic [NBANK-1:0]              bank_en,
  output logic                          hit,
  output logic [BIDX_W-1:0]             hit_idx,
  output logic [1:0]                    hit_tim,
  output logic [ROW_W-1:0]              hit_row,
  output logic [COL_W-1:0]              hit_col
);

  logic [BLK_W-1:0]  blk;
  logic [NBANK-1:0]  sel;
  logic [ADDR_W-1:0] off;
  logic [OFF_W-2:0]  word;
  logic              unused_bits;

  assign blk = addr[ADDR_W-1:BLK_SH];

  for (genvar g = 0; g < NBANK; g++) begin : g_cmp
    logic [BLK_W-1:0] rel;
    assign rel    = blk - bank_base[g];
    assign sel[g] = bank_en[g] && (blk >= bank_base[g]) && (rel < bank_size[g]);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (sel[i]) begin
        hit     = 1'b1;
        hit_idx = BIDX_W'(i);
      end
    end
  end

  assign off     = addr - {bank_base[hit_idx], {BLK_SH{1'b0}}};
  assign word    = off[OFF_W-1:1];
  assign hit_row = word[ROW_W+COL_W-1:COL_W];
  assign hit_col = word[COL_W-1:0];
  assign hit_tim = bank_tim[hit_idx];

  assign unused_bits = ^{off[ADDR_W-1:OFF_W], off[0]};

endmodule

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int REF_W    = 12,
  parameter int REF_DEF  = 64,
  parameter int CFG_A_W  = 3,
  parameter int CFG_W    = 19,
  parameter int REF_SLOT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_A_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               ref_ack,
  output logic               ref_pend
);

  logic [REF_W-1:0] ivl_q;
  logic [REF_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q    <= REF_W'(REF_DEF);
      cnt_q    <= REF_W'(REF_DEF);
      ref_pend <= 1'b0;
    end else begin
      if (ref_ack) ref_pend <= 1'b0;
      if (cfg_we && cfg_addr == CFG_A_W'(REF_SLOT)) begin
        ivl_q <= cfg_wdata[REF_W-1:0];
        cnt_q <= cfg_wdata[REF_W-1:0];
      end else if (cnt_q == '0) begin
        cnt_q    <= ivl_q - 1'b1;
        ref_pend <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpm_access_seq.sv
module fpm_access_seq
  import fpm_pkg::*;
#(
  parameter int NBANK  = 6,
  parameter int BIDX_W = 3,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DATA_W = 16,
  localparam int DA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hit,
  input  logic [BIDX_W-1:0] hit_idx,
  input  logic [1:0]        hit_tim,
  input  logic [ROW_W-1:0]  hit_row,
  input  logic [COL_W-1:0]  hit_col,
  input  logic              ref_pend,
  input  logic [DATA_W-1:0] dram_dq_in,
  output logic              ref_ack,
  output logic              req_ready,
  output logic              req_err,
  output logic [DATA_W-1:0] req_rdata,
  output logic [DA_W-1:0]   dram_addr,
  output logic [NBANK-1:0]  dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe
);

  seq_state_e        st_q, st_d;
  logic [BIDX_W-1:0] idx_q, c_idx;
  logic [1:0]        tim_q, c_tim;
  logic [ROW_W-1:0]  row_q, c_row;
  logic [COL_W-1:0]  col_q, c_col;
  logic              wr_q, c_wr;
  logic [DATA_W-1:0] wd_q, c_wd;
  logic [NBANK-1:0]  bank_oh;
  logic              idle;

  assign idle  = (st_q == ST_IDLE);
  assign c_idx = idle ? hit_idx   : idx_q;
  assign c_tim = idle ? hit_tim   : tim_q;
  assign c_row = idle ? hit_row   : row_q;
  assign c_col = idle ? hit_col   : col_q;
  assign c_wr  = idle ? req_write : wr_q;
  assign c_wd  = idle ? req_wdata : wd_q;
  assign bank_oh = NBANK'(1) << c_idx;

  always_comb begin
    st_d    = st_q;
    ref_ack = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend) begin
          st_d    = ST_RF_CAS;
          ref_ack = 1'b1;
        end else if (req_valid) begin
          st_d = hit ? ST_RAS : ST_ERR;
        end
      end
      ST_RAS:     st_d = (c_tim != TM_3CLK) ? ST_RCD : ST_CAS;
      ST_RCD:     st_d = ST_CAS;
      ST_CAS:     st_d = c_tim[1] ? ST_CASW : ST_DATA;
      ST_CASW:    st_d = ST_DATA;
      ST_DATA:    st_d = ST_IDLE;
      ST_ERR:     st_d = ST_IDLE;
      ST_RF_CAS:  st_d = ST_RF_RAS;
      ST_RF_RAS:  st_d = ST_RF_HOLD;
      ST_RF_HOLD: st_d = ST_RF_PRE;
      ST_RF_PRE:  st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // outputs are registered from the next state so pins change with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      tim_q       <= '0;
      row_q       <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wd_q        <= '0;
      req_ready   <= 1'b0;
      req_err     <= 1'b0;
      req_rdata   <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= '1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (idle && st_d == ST_RAS) begin
        idx_q <= hit_idx;
        tim_q <= hit_tim;
        row_q <= hit_row;
        col_q <= hit_col;
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      if ((st_q == ST_CAS || st_q == ST_CASW) && st_d == ST_DATA)
        req_rdata <= dram_dq_in;

      req_ready <= (st_d == ST_DATA) || (st_d == ST_ERR);
      req_err   <= (st_d == ST_ERR);

      unique case (st_d)
        ST_RAS, ST_RCD, ST_CAS, ST_CASW: dram_ras_n <= ~bank_oh;
        ST_RF_RAS, ST_RF_HOLD:           dram_ras_n <= '0;
        default:                         dram_ras_n <= '1;
      endcase

      dram_cas_n <= !(st_d == ST_CAS || st_d == ST_CASW || st_d == ST_RF_CAS ||
                      st_d == ST_RF_RAS || st_d == ST_RF_HOLD);

      if (st_d == ST_RAS || st_d == ST_RCD)
        dram_addr <= DA_W'(c_row);
      else if (st_d == ST_CAS || st_d == ST_CASW)
        dram_addr <= DA_W'(c_col);

      dram_we_n   <= !((st_d == ST_CAS || st_d == ST_CASW) && c_wr);
      dram_dq_oe  <= (st_d == ST_CAS || st_d == ST_CASW) && c_wr;
      dram_dq_out <= c_wd;
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int NBANK   = 6,
  parameter int ADDR_W  = 24,
  parameter int BLK_SH  = 16,
  parameter int ROW_W   = 11,
  parameter int COL_W   = 11,
  parameter int DATA_W  = 16,
  parameter int REF_W   = 12,
  parameter int REF_DEF = 64,
  localparam int BLK_W   = ADDR_W - BLK_SH,
  localparam int CFG_W   = 2 * BLK_W + 3,
  localparam int CFG_A_W = $clog2(NBANK + 1),
  localparam int BIDX_W  = $clog2(NBANK),
  localparam int DA_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_A_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               req_err,
  output logic [DATA_W-1:0]  req_rdata,
  output logic [DA_W-1:0]    dram_addr,
  output logic [NBANK-1:0]   dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic [DATA_W-1:0]  dram_dq_out,
  output logic               dram_dq_oe,
  input  logic [DATA_W-1:0]  dram_dq_in
);

  logic [NBANK-1:0][BLK_W-1:0] bank_base;
  logic [NBANK-1:0][BLK_W-1:0] bank_size;
  logic [NBANK-1:0][1:0]       bank_tim;
  logic [NBANK-1:0]            bank_en;
  logic                        hit;
  logic [BIDX_W-1:0]           hit_idx;
  logic [1:0]                  hit_tim;
  logic [ROW_W-1:0]            hit_row;
  logic [COL_W-1:0]            hit_col;
  logic                        ref_pend;
  logic                        ref_ack;

  fpm_bank_regs #(
    .NBANK(NBANK), .BLK_W(BLK_W), .CFG_A_W(CFG_A_W), .CFG_W(CFG_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bank_base(bank_base), .bank_size(bank_size),
    .bank_tim(bank_tim), .bank_en(bank_en)
  );

  fpm_bank_match #(
    .NBANK(NBANK), .ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .ROW_W(ROW_W),
    .COL_W(COL_W), .BIDX_W(BIDX_W)
  ) u_match (
    .addr(req_addr), .bank_base(bank_base), .bank_size(bank_size),
    .bank_tim(bank_tim), .bank_en(bank_en), .hit(hit), .hit_idx(hit_idx),
    .hit_tim(hit_tim), .hit_row(hit_row), .hit_col(hit_col)
  );

  fpm_refresh_timer #(
    .REF_W(REF_W), .REF_DEF(REF_DEF), .CFG_A_W(CFG_A_W), .CFG_W(CFG_W),
    .REF_SLOT(NBANK)
  ) u_refresh (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  fpm_access_seq #(
    .NBANK(NBANK), .BIDX_W(BIDX_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .hit(hit), .hit_idx(hit_idx), .hit_tim(hit_tim),
    .hit_row(hit_row), .hit_col(hit_col), .ref_pend(ref_pend),
    .dram_dq_in(dram_dq_in), .ref_ack(ref_ack), .req_ready(req_ready),
    .req_err(req_err), .req_rdata(req_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
  );

endmodule

// File: rtl/fpm_dram_checker.sv
module fpm_dram_checker #(
  parameter int NBANK = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [NBANK-1:0] ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic             req_ready,
  input logic             req_err
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ras_n == '1 && cas_n && we_n && !req_ready)); // R1

  AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(~ras_n) || ras_n == '0)); // R2

  AST_ERR_NO_RAS: assert property (@(posedge clk) disable iff (rst)
    req_err |-> (ras_n == '1)); // R4

  AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    req_err |-> req_ready); // R4

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready); // R6

  AST_ROW_BEFORE_COL: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && ras_n != '1) |-> ($past(ras_n) == ras_n)); // R6

  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!cas_n && dq_oe)); // R7

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
    (ras_n == '0 && $past(ras_n) == '1) |-> $past(!cas_n)); // R8

  AST_REF_NOT_IN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && ras_n == '1) |-> $past(ras_n == '1)); // R11

endmodule

bind fpm_dram_ctrl fpm_dram_checker #(.NBANK(NBANK)) u_fpm_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .dq_oe(dram_dq_oe), .req_ready(req_ready),
  .req_err(req_err)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;

  localparam int REF_DEF = 64;
  localparam int NV      = 12;

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [2:0]  bank;   // 7 = no enabled bank hit
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0, 24'h000100, 16'h0000, 3'd0, 4'd3},  // R6 code 0
    '{1'b1, 24'h0FFFFE, 16'hBEEF, 3'd0, 4'd3},  // R2 last word of bank 0
    '{1'b0, 24'h100000, 16'h0000, 3'd1, 4'd4},  // R2 contiguous neighbour
    '{1'b1, 24'h17FFFE, 16'h1234, 3'd1, 4'd4},  // R2 top of bank 1
    '{1'b0, 24'h180000, 16'h0000, 3'd7, 4'd1},  // R4 gap
    '{1'b0, 24'h400000, 16'h0000, 3'd2, 4'd5},  // R6 code 2
    '{1'b1, 24'hBFFFFE, 16'hA5A5, 3'd2, 4'd5},  // R5 max row and column
    '{1'b0, 24'hC00000, 16'h0000, 3'd7, 4'd1},  // R4 past bank 2
    '{1'b0, 24'h200002, 16'h0000, 3'd3, 4'd5},  // R6 code 3
    '{1'b0, 24'h280000, 16'h0000, 3'd7, 4'd1},  // R12 disabled bank
    '{1'b0, 24'h030000, 16'h0000, 3'd0, 4'd3},  // R3 overlap
    '{1'b1, 24'h023456, 16'h5AC3, 3'd0, 4'd3}   // R3 overlap write
  };

  localparam logic [7:0] BASE_B [6] = '{8'h00, 8'h10, 8'h40, 8'h20, 8'h28, 8'h02};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, req_err;
  logic [15:0] req_rdata;
  logic [10:0] dram_addr;
  logic [5:0]  dram_ras_n;
  logic        dram_cas_n, dram_we_n, dram_dq_oe;
  logic [15:0] dram_dq_out, dram_dq_in;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cbr_cnt = 0;
  int t_first = -1;
  int t_prev = 0;
  int t_last = 0;
  logic prev_cas = 1'b1;

  always #4 clk = ~clk;

  // memory model: returns a column-tagged word while the column strobe is low
  assign dram_dq_in = dram_cas_n ? 16'h0000 : {5'h15, dram_addr};

  fpm_dram_ctrl u_fpm_dram_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_err(req_err), .req_rdata(req_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!dram_cas_n && dram_ras_n == 6'h3F && prev_cas) begin
        if (t_first < 0) t_first = cyc;
        t_prev = t_last;
        t_last = cyc;
        cbr_cnt++;
      end
      prev_cas = dram_cas_n;
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    summary();
    $finish;
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [18:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [23:0] a, input logic [15:0] wd,
                        output int lat, output int bank, output logic [10:0] row,
                        output logic [10:0] col, output logic we_low, output logic [15:0] dq,
                        output logic err, output logic [15:0] rd);
    logic col_got;
    logic done;
    bank = -1; row = '0; col = '0; we_low = 1'b0; dq = '0; err = 1'b0; rd = '0;
    col_got = 1'b0; done = 1'b0; lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!done) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (dram_ras_n != 6'h3F && dram_ras_n != 6'h00) begin
        if (bank < 0) begin
          for (int i = 0; i < 6; i++) if (!dram_ras_n[i]) bank = i;
          row = dram_addr;
        end
        if (!dram_cas_n && !col_got) begin
          col_got = 1'b1;
          col = dram_addr;
          we_low = !dram_we_n && dram_dq_oe;
          dq = dram_dq_out;
        end
      end
      if (req_ready) begin
        done = 1'b1;
        err = req_err;
        rd = req_rdata;
      end
      if (lat > 40) done = 1'b1;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    int lat, bank;
    logic [10:0] row, col;
    logic we_low, err;
    logic [15:0] dq, rd;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 outputs right after reset
    chk("R1", "ras_n", dram_ras_n, 6'h3F);
    chk("R1", "cas_n", dram_cas_n, 1);
    chk("R1", "we_n", dram_we_n, 1);
    chk("R1", "ready", req_ready, 0);

    // R9 first refresh with default interval
    for (int k = 0; k < 200 && cbr_cnt == 0; k++) @(negedge clk);
    chk("R9", "first refresh cycle", t_first, REF_DEF + 2);

    // R1 all banks disabled after reset
    access(1'b0, 24'h000000, 16'h0, lat, bank, row, col, we_low, dq, err, rd);
    chk("R1", "unconfigured err", err, 1);
    chk("R1", "unconfigured bank", bank, -1);

    // R10 programmed interval
    begin
      int c0;
      cfg(3'd6, 19'd50);
      c0 = cbr_cnt;
      for (int k = 0; k < 400 && cbr_cnt < c0 + 2; k++) @(negedge clk);
      chk("R10", "refresh spacing", t_last - t_prev, 50);
    end

    cfg(3'd6, 19'd4000);
    cfg(3'd0, {1'b1, 2'd0, 8'h10, 8'h00});
    cfg(3'd1, {1'b1, 2'd1, 8'h08, 8'h10});
    cfg(3'd2, {1'b1, 2'd2, 8'h80, 8'h40});
    cfg(3'd3, {1'b1, 2'd3, 8'h08, 8'h20});
    cfg(3'd4, {1'b0, 2'd0, 8'h08, 8'h28});
    cfg(3'd5, {1'b1, 2'd1, 8'h04, 8'h02});

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      logic [23:0] off;
      logic [21:0] w;
      v = TBL[k];
      access(v.wr, v.addr, v.wd, lat, bank, row, col, we_low, dq, err, rd);
      chk("R6", "latency", lat, v.lat);
      if (v.bank == 3'd7) begin
        chk("R4", "err flag", err, 1);
        chk("R4", "no bank strobe", bank, -1);
      end else begin
        off = v.addr - {BASE_B[v.bank], 16'h0000};
        w = off[22:1];
        chk("R2", "bank strobe", bank, v.bank);
        chk("R5", "row", row, w[21:11]);
        chk("R5", "column", col, w[10:0]);
        chk("R4", "no err on hit", err, 0);
        if (v.wr) begin
          chk("R7", "write strobe", we_low, 1);
          chk("R7", "write data", dq, v.wd);
        end else begin
          chk("R7", "read no write strobe", we_low, 0);
          chk("R7", "read data", rd, {5'h15, w[10:0]});
        end
      end
    end

    // R11 fast refresh interleaved with accesses
    begin
      int c0, slow, maxlat;
      logic ok;
      slow = 0; maxlat = 0; ok = 1'b1;
      cfg(3'd6, 19'd12);
      c0 = cbr_cnt;
      for (int k = 0; k < 16; k++) begin
        access(1'b0, 24'(k * 2), 16'h0, lat, bank, row, col, we_low, dq, err, rd);
        if (lat > 3) slow++;
        if (lat > maxlat) maxlat = lat;
        if (rd != {5'h15, 11'(k)} || bank != 0) ok = 1'b0;
      end
      chk("R11", "data intact under refresh", ok, 1);
      chk("R11", "max latency <= 8", maxlat <= 8, 1);
      chk("R11", "some access delayed", slow > 0, 1);
      chk("R8", "refreshes issued", cbr_cnt > c0, 1);
    end

    summary();
    $finish;
  end

endmodule